// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Coherent Seconds Snapshot

This block keeps wall-clock time as two counters: a seconds count and a sub-second millisecond count. A single-cycle `ms_tick` pulse from an always-on time base advances the millisecond count. When the millisecond count rolls over, the seconds count increments. Because the time base is meant to keep running through low-power states, the block can serve as a persistent clock for software.

Software reads the counters through a small memory-mapped register interface. Reading seconds and milliseconds as two separate bus accesses would be unsafe, because a rollover could fall between them. To prevent this, a read of the millisecond register also copies the live seconds value into a separate shadow register at the same clock edge. Software reads milliseconds first and then the shadow seconds, and computes the total as seconds × 1000 + milliseconds. Software can also set the time by writing the live seconds register.

Top module: `msec_rtc`

## Requirements
- R1: After reset, the live seconds, the shadow seconds and the millisecond count all read as zero.
- R2: Each cycle with `ms_tick` high advances the millisecond count by one. In cycles without a tick, the count holds its value.
- R3: A tick that arrives while the millisecond count equals MS_PER_SEC-1 sets the millisecond count to 0 and increments the live seconds. The seconds count wraps from 0xFFFFFFFF to 0.
- R4: A read of offset 0x10 returns the millisecond count, zero-extended to 32 bits. At the same edge, it copies the live seconds into the shadow register. The shadow register changes on no other event.
- R5: A read of offset 0x08 returns the live seconds. A read of offset 0x0c returns the shadow seconds. Read data appears on `bus_rdata` one clock edge after the read is accepted, and holds until the next read.
- R6: When a tick and a read of offset 0x10 occur in the same cycle, the read returns the millisecond value from before the tick. The shadow register captures the seconds value from before the tick.
- R7: A write to offset 0x08 loads the live seconds with the write data and clears the millisecond count. The write takes precedence over a tick in the same cycle.
- R8: Writes to offset 0x0c, to offset 0x10, or to any other offset except 0x08 leave every counter and the shadow register unchanged.
- R9: A read of any offset other than 0x08, 0x0c or 0x10 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond advance pulse |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with MS_PER_SEC set to 5 instead of 1000. With this setting, a millisecond rollover and the resulting seconds increment take only a few ticks. Many rollovers and shadow captures therefore fit into a short run. The seconds wrap is reached by first writing 0xFFFFFFFF and then ticking through one rollover. The collisions between a tick and a read or a write in the same cycle are driven on exact cycles, to pin down which value wins.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_LIVE   = 2'd1,
    REG_SHADOW = 2'd2,
    REG_MSEC   = 2'd3
  } rtc_reg_e;
endpackage

// File: rtl/rtc_msec_count.sv
module rtc_msec_count #(
  parameter int MS_PER_SEC = 1000,
  parameter int MS_W       = $clog2(MS_PER_SEC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            clear,
  output logic [MS_W-1:0] ms_q,
  output logic            carry
);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);
  localparam logic [MS_W-1:0] MS_LIM  = MS_W'(MS_PER_SEC);

  logic [MS_W-1:0] ms_d;
  logic            ms_en;
  logic            at_last;

  assign at_last = (ms_q == MS_LAST);
  assign carry   = tick && at_last && !clear;
  assign ms_en   = clear || tick;

  always_comb begin
    ms_d = ms_q;
    if (clear)        ms_d = '0;
    else if (at_last) ms_d = '0;
    else              ms_d = ms_q + MS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ms_q <= '0;
    else if (ms_en) ms_q <= ms_d;
  end

  // R2: the count never leaves its range
  a_r2_ms_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q < MS_LIM);
  // R2: no tick and no clear, so the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(ms_q));
  // R3: a tick at the last value returns the count to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && ms_q == MS_LAST) |=> (ms_q == '0));
  // R7: a clear always wins
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ms_q == '0));
endmodule

// File: rtl/rtc_sec_count.sv
module rtc_sec_count #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  input  logic             inc,
  output logic [SEC_W-1:0] sec_q
);
  logic [SEC_W-1:0] sec_d;
  logic             sec_en;

  assign sec_en = load || inc;

  always_comb begin
    if (load) sec_d = load_val;
    else      sec_d = sec_q + SEC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sec_q <= '0;
    else if (sec_en) sec_q <= sec_d;
  end

  // R3: a rollover carry advances seconds by one, modulo 2^SEC_W
  a_r3_sec_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (sec_q == $past(sec_q) + SEC_W'(1)));
  // R7: a load takes the written value
  a_r7_sec_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec_q == $past(load_val)));
  // R8: without load or carry, seconds hold
  a_r8_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc) |=> $stable(sec_q));
endmodule

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
  import rtc_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] OFS_LIVE   = ADDR_W'(8'h08),
  parameter logic [ADDR_W-1:0] OFS_SHADOW = ADDR_W'(8'h0c),
  parameter logic [ADDR_W-1:0] OFS_MSEC   = ADDR_W'(8'h10)
) (
  input  logic [ADDR_W-1:0] addr,
  output rtc_reg_e          reg_sel
);
  always_comb begin
    unique case (addr)
      OFS_LIVE:   reg_sel = REG_LIVE;
      OFS_SHADOW: reg_sel = REG_SHADOW;
      OFS_MSEC:   reg_sel = REG_MSEC;
      default:    reg_sel = REG_NONE;
    endcase
  end
endmodule

// File: rtl/msec_rtc.sv
module msec_rtc
  import rtc_pkg::*;
#(
  parameter int MS_PER_SEC = 1000,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int MS_W = $clog2(MS_PER_SEC + 1);

  rtc_reg_e          reg_sel;
  logic              rd_en, wr_en;
  logic              sec_load, snap;
  logic              carry;
  logic [MS_W-1:0]   ms_q;
  logic [DATA_W-1:0] sec_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] rdata_d;

  assign rd_en    = bus_sel && !bus_wr;
  assign wr_en    = bus_sel && bus_wr;
  assign sec_load = wr_en && (reg_sel == REG_LIVE);
  assign snap     = rd_en && (reg_sel == REG_MSEC);

  rtc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .reg_sel (reg_sel)
  );

  rtc_msec_count #(.MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_ms (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (ms_tick),
    .clear (sec_load),
    .ms_q  (ms_q),
    .carry (carry)
  );

  rtc_sec_count #(.SEC_W(DATA_W)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sec_load),
    .load_val (bus_wdata),
    .inc      (carry),
    .sec_q    (sec_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow_q <= '0;
    else if (snap) shadow_q <= sec_q;
  end

  always_comb begin
    unique case (reg_sel)
      REG_LIVE:   rdata_d = sec_q;
      REG_SHADOW: rdata_d = shadow_q;
      REG_MSEC:   rdata_d = DATA_W'(ms_q);
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rdata_d;
  end

  // R4 / R6: a millisecond read captures the pre-edge seconds
  a_r4_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (shadow_q == $past(sec_q)));
  // R4: the shadow moves only on a millisecond read
  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(shadow_q));
  // R9: undefined offsets read zero
  a_r9_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == REG_NONE) |=> (bus_rdata == '0));
  // R5: read data holds between reads
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bus_rdata));
endmodule

// File: tb/msec_rtc_tb.sv
module msec_rtc_tb;
  localparam int MSPS = 5;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_TK = 2'd2;
  localparam int NV = 26;
  // {req[3:0], op[1:0], addr[7:0], value[31:0]}
  localparam logic [45:0] VEC [NV] = '{
    {4'd1, OP_RD, 8'h10, 32'd0},     // R1
    {4'd1, OP_RD, 8'h08, 32'd0},     // R1
    {4'd1, OP_RD, 8'h0c, 32'd0},     // R1
    {4'd2, OP_TK, 8'h00, 32'd3},
    {4'd2, OP_RD, 8'h10, 32'd3},     // R2
    {4'd2, OP_RD, 8'h10, 32'd3},     // R2 hold
    {4'd3, OP_TK, 8'h00, 32'd2},
    {4'd3, OP_RD, 8'h08, 32'd1},     // R3
    {4'd3, OP_RD, 8'h10, 32'd0},     // R3
    {4'd4, OP_RD, 8'h0c, 32'd1},     // R4
    {4'd4, OP_TK, 8'h00, 32'd7},
    {4'd4, OP_RD, 8'h0c, 32'd1},     // R4 shadow unchanged
    {4'd4, OP_RD, 8'h10, 32'd2},     // R4
    {4'd5, OP_RD, 8'h0c, 32'd2},     // R5
    {4'd7, OP_WR, 8'h08, 32'h100},
    {4'd7, OP_RD, 8'h10, 32'd0},     // R7
    {4'd7, OP_RD, 8'h08, 32'h100},   // R7
    {4'd8, OP_WR, 8'h0c, 32'hDEAD},
    {4'd8, OP_RD, 8'h0c, 32'h100},   // R8
    {4'd8, OP_TK, 8'h00, 32'd2},
    {4'd8, OP_WR, 8'h10, 32'd3},
    {4'd8, OP_RD, 8'h10, 32'd2},     // R8
    {4'd8, OP_RD, 8'h08, 32'h100},   // R8
    {4'd9, OP_RD, 8'h04, 32'd0},     // R9
    {4'd9, OP_RD, 8'h14, 32'd0},     // R9
    {4'd9, OP_RD, 8'h00, 32'd0}      // R9
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ms_tick;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msec_rtc #(.MS_PER_SEC(MSPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    bus_sel = 1'b0; bus_wr = 1'b0; ms_tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk); idle(); d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); idle();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
    end
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(); bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rdata after reset", bus_rdata, 32'd0);

    for (int k = 0; k < NV; k++) begin
      logic [45:0] v = VEC[k];
      unique case (v[41:40])
        OP_RD: begin
          rd(v[39:32], d);
          check($sformatf("R%0d vector %0d", v[45:42], k), d, v[31:0]);
        end
        OP_WR: wr(v[39:32], v[31:0]);
        default: ticks(int'(v[31:0]));
      endcase
    end

    // R6: tick and millisecond read in the same cycle
    wr(8'h08, 32'd7);
    ticks(4);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h10; ms_tick = 1'b1;
    @(negedge clk); idle(); d = bus_rdata;
    check("R6 ms before tick", d, 32'd4);
    rd(8'h0c, d); check("R6 shadow before tick", d, 32'd7);
    rd(8'h08, d); check("R6 live after tick", d, 32'd8);

    // R7: seconds write wins over a tick in the same cycle
    ticks(3);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08;
    bus_wdata = 32'h50; ms_tick = 1'b1;
    @(negedge clk); idle();
    rd(8'h10, d); check("R7 ms cleared over tick", d, 32'd0);
    rd(8'h08, d); check("R7 load over tick", d, 32'h50);

    // R3: seconds wrap past all ones
    wr(8'h08, 32'hFFFF_FFFF);
    ticks(MSPS);
    rd(8'h08, d); check("R3 seconds wrap", d, 32'd0);
    rd(8'h10, d); check("R3 ms after wrap", d, 32'd0);

    // R1: reset in mid-run
    ticks(2);
    rd(8'h10, d);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 rdata mid reset", bus_rdata, 32'd0);
    rd(8'h0c, d); check("R1 shadow mid reset", d, 32'd0);
    rd(8'h10, d); check("R1 ms mid reset", d, 32'd0);
    rd(8'h08, d); check("R1 live mid reset", d, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule